// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and calendar date for a chip that receives a 32,768 Hz timebase. Every oscillator period arrives as a one-cycle pulse on `osc_tick` in the system clock domain. A fractional prescaler turns those pulses into 100 Hz hundredths steps. The steps drive a chain of packed-BCD counters:

- hundredths
- seconds
- minutes
- hours in 24-hour form
- day of week
- date
- month
- two-digit year
- a century flag

The date counter finds the month length from the month and the year, so February gains its 29th day in every year divisible by four.

A host interface reaches the block through a byte-wide parallel port. A host write loads one register of the live counters directly. Reads come from a visible copy of the counters. That copy follows the live count one cycle behind. While `host_hold` is high, the copy stays frozen, so a multi-byte read returns a single consistent instant while the live count keeps running. The copy catches up when the hold is released.

Top module: `bcd_rtc_core`

## Requirements
- R1: Each `osc_tick` pulse adds TICK_HZ (100) to a running total. A hundredths step is issued on the pulse at which that total reaches OSC_HZ, and OSC_HZ is then subtracted. With OSC_HZ = 32768, the first step comes on the 328th pulse, and 32768 pulses make exactly 100 steps (one second).
- R2: Address 0 holds the hundredths byte, with tenths in bits 7:4 and hundredths in bits 3:0. It counts 00 to 99 in BCD and carries into seconds when it wraps. After reset the clock reads 00:00:00.00, day of week 01, date 01, month 01, year 00, century 0.
- R3: Seconds (address 1) and minutes (address 2) count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R4: Hours (address 3) count 00 to 23 in BCD. The wrap from 23 to 00 advances both the day of week and the date.
- R5: Day of week (address 4) counts 01 to 07 and wraps from 07 to 01 at midnight.
- R6: Date (address 5) wraps to 01 after the last day of the month: 31 for months 01, 03, 05, 07, 08, 10 and 12; 30 for months 04, 06, 09 and 11; 28 or 29 for month 02. Each date wrap advances the month (address 6). The month wraps from 12 to 01 and advances the year.
- R7: Year (address 7) counts 00 to 99 in BCD. February has 29 days whenever the year is divisible by four, including year 00.
- R8: When the year wraps from 99 to 00, the century flag toggles. The flag is bit 0 of address 8, and the other bits of address 8 read as 0.
- R9: A cycle with `host_we` high loads `host_wdata` into the register at `host_addr` at that clock edge. In such a cycle any pending hundredths step is discarded. A write to address 0 also restarts the prescaler total at zero. Writes to addresses 9 to 15 change nothing, and those addresses read as 00.
- R10: `host_rdata` shows the visible copy. While `host_hold` is low, the copy takes the live count one cycle after each change. While `host_hold` is high, the copy stays frozen. After release it shows the current live count within two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per period of the 32,768 Hz timebase |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address for reads and writes |
| host_wdata | input | 8 | Write data in BCD |
| host_hold | input | 1 | Freezes the visible copy during a read burst |
| host_rdata | output | 8 | Visible copy of the addressed register |

## Verification
The bench loads times just before cascaded rollovers: end of year with the century flag, February in leap and common years including year 00, and 30-day months. A design with a wrong month table or leap rule would land on the wrong date, and a broken carry enable would leave an upper field unchanged. A long run of 32,768 pulses shows whether the prescaler drifts: an integer divider or an off-by-one comparison would end away from exactly one second. Further checks confirm that a step falling in a write cycle is discarded, and that a held read stays frozen and then catches up after release.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned ADDR_W = 4;

    typedef logic [7:0] bcd8_t;

    localparam logic [ADDR_W-1:0] ADDR_HUND  = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_SEC   = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_MIN   = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_HOUR  = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_DOW   = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_DATE  = 4'd5;
    localparam logic [ADDR_W-1:0] ADDR_MONTH = 4'd6;
    localparam logic [ADDR_W-1:0] ADDR_YEAR  = 4'd7;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd8;

    typedef struct packed {
        bcd8_t hund;
        bcd8_t sec;
        bcd8_t min;
        bcd8_t hour;
        bcd8_t dow;
        bcd8_t date;
        bcd8_t month;
        bcd8_t year;
        logic  century;
    } rtc_time_t;

    localparam rtc_time_t TIME_RESET = '{
        hund: 8'h00, sec: 8'h00, min: 8'h00, hour: 8'h00,
        dow: 8'h01, date: 8'h01, month: 8'h01, year: 8'h00, century: 1'b0
    };

    typedef struct packed {
        logic  carry;
        bcd8_t value;
    } bcd_step_t;

    // Advance a two-digit BCD value; at or past 'last' it returns 'first' with carry.
    function automatic bcd_step_t bcd_advance(bcd8_t cur, bcd8_t last, bcd8_t first);
        bcd_step_t r;
        if (cur >= last) begin
            r.carry = 1'b1;
            r.value = first;
        end else begin
            r.carry = 1'b0;
            if (cur[3:0] >= 4'd9) r.value = {cur[7:4] + 4'd1, 4'd0};
            else                  r.value = {cur[7:4], cur[3:0] + 4'd1};
        end
        return r;
    endfunction

    // Divisible by four: odd tens need ones 2 or 6, even tens need 0, 4 or 8.
    function automatic logic year_is_leap(bcd8_t y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic bcd8_t month_length(bcd8_t month, bcd8_t year);
        case (month)
            8'h02:                      return year_is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned OSC_HZ  = 32768,
    parameter int unsigned TICK_HZ = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic restart,
    output logic tick_o
);
    localparam int unsigned ACC_W = $clog2(OSC_HZ + TICK_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(TICK_HZ);
    localparam logic [ACC_W-1:0] WRAP = ACC_W'(OSC_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             hit;

    always_comb begin
        sum = acc_q + STEP;
        hit = osc_tick && (sum >= WRAP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= hit;
            if (restart)       acc_q <= '0;
            else if (osc_tick) acc_q <= hit ? (sum - WRAP) : sum;
        end
    end

    // R1: a hundredths step only follows a timebase pulse
    assert_tick_after_osc_R1: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(osc_tick));

    // R1: without a timebase pulse the total holds
    assert_acc_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (!osc_tick && !restart) |=> $stable(acc_q));

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  bcd8_t             wr_data,
    output rtc_time_t         live_o
);
    rtc_time_t live_q;
    rtc_time_t nxt;
    bcd_step_t s_hund, s_sec, s_min, s_hour, s_dow, s_date, s_month, s_year;
    bcd8_t     dim;
    logic      adv_sec, adv_min, adv_hour, adv_day, adv_month, adv_year, adv_cent;

    always_comb begin
        dim     = month_length(live_q.month, live_q.year);
        s_hund  = bcd_advance(live_q.hund,  8'h99, 8'h00);
        s_sec   = bcd_advance(live_q.sec,   8'h59, 8'h00);
        s_min   = bcd_advance(live_q.min,   8'h59, 8'h00);
        s_hour  = bcd_advance(live_q.hour,  8'h23, 8'h00);
        s_dow   = bcd_advance(live_q.dow,   8'h07, 8'h01);
        s_date  = bcd_advance(live_q.date,  dim,   8'h01);
        s_month = bcd_advance(live_q.month, 8'h12, 8'h01);
        s_year  = bcd_advance(live_q.year,  8'h99, 8'h00);

        adv_sec   = tick      & s_hund.carry;
        adv_min   = adv_sec   & s_sec.carry;
        adv_hour  = adv_min   & s_min.carry;
        adv_day   = adv_hour  & s_hour.carry;
        adv_month = adv_day   & s_date.carry;
        adv_year  = adv_month & s_month.carry;
        adv_cent  = adv_year  & s_year.carry;

        nxt = live_q;
        if (tick)      nxt.hund  = s_hund.value;
        if (adv_sec)   nxt.sec   = s_sec.value;
        if (adv_min)   nxt.min   = s_min.value;
        if (adv_hour)  nxt.hour  = s_hour.value;
        if (adv_day) begin
            nxt.dow  = s_dow.value;
            nxt.date = s_date.value;
        end
        if (adv_month) nxt.month = s_month.value;
        if (adv_year)  nxt.year  = s_year.value;
        if (adv_cent)  nxt.century = ~live_q.century;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= TIME_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_HUND:  live_q.hund    <= wr_data;
                ADDR_SEC:   live_q.sec     <= wr_data;
                ADDR_MIN:   live_q.min     <= wr_data;
                ADDR_HOUR:  live_q.hour    <= wr_data;
                ADDR_DOW:   live_q.dow     <= wr_data;
                ADDR_DATE:  live_q.date    <= wr_data;
                ADDR_MONTH: live_q.month   <= wr_data;
                ADDR_YEAR:  live_q.year    <= wr_data;
                ADDR_CTRL:  live_q.century <= wr_data[0];
                default: ;
            endcase
        end else if (tick) begin
            live_q <= nxt;
        end
    end

    assign live_o = live_q;

    // R3: seconds wrap from 59 to 00 on a hundredths carry
    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && live_q.hund == 8'h99 && live_q.sec == 8'h59) |=> live_q.sec == 8'h00);

    // R4: a day advance leaves the clock at midnight
    assert_midnight_R4: assert property (@(posedge clk) disable iff (rst)
        (adv_day && !wr_en) |=> (live_q.hour == 8'h00 && live_q.min == 8'h00 && live_q.sec == 8'h00));

    // R5: day of week returns to 01 after 07
    assert_dow_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (adv_day && !wr_en && live_q.dow == 8'h07) |=> live_q.dow == 8'h01);

    // R6: the last day of the month wraps to the first
    assert_date_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (adv_day && !wr_en && live_q.date == dim) |=> live_q.date == 8'h01);

    // R8: year rollover flips the century flag
    assert_century_R8: assert property (@(posedge clk) disable iff (rst)
        (adv_year && !wr_en && live_q.year == 8'h99) |=> live_q.century != $past(live_q.century));

    // R9: a write lands in the addressed register
    assert_write_hour_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_HOUR) |=> live_q.hour == $past(wr_data));

    // R9: no counting during a write cycle
    assert_write_blocks_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != ADDR_HUND) |=> $stable(live_q.hund));

endmodule

// File: rtl/rtc_readport.sv
module rtc_readport
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  rtc_time_t         live_i,
    input  logic [ADDR_W-1:0] addr,
    output bcd8_t             rdata
);
    rtc_time_t snap_q;

    always_ff @(posedge clk) begin
        if (rst)        snap_q <= TIME_RESET;
        else if (!hold) snap_q <= live_i;
    end

    always_comb begin
        case (addr)
            ADDR_HUND:  rdata = snap_q.hund;
            ADDR_SEC:   rdata = snap_q.sec;
            ADDR_MIN:   rdata = snap_q.min;
            ADDR_HOUR:  rdata = snap_q.hour;
            ADDR_DOW:   rdata = snap_q.dow;
            ADDR_DATE:  rdata = snap_q.date;
            ADDR_MONTH: rdata = snap_q.month;
            ADDR_YEAR:  rdata = snap_q.year;
            ADDR_CTRL:  rdata = {7'd0, snap_q.century};
            default:    rdata = 8'h00;
        endcase
    end

    // R10: the visible copy is frozen during a hold
    assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(snap_q));

    // R10: without a hold the copy trails the live count by one cycle
    assert_follow_live_R10: assert property (@(posedge clk) disable iff (rst)
        !hold |=> snap_q == $past(live_i));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned OSC_HZ  = 32768,
    parameter int unsigned TICK_HZ = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       host_we,
    input  logic [3:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_hold,
    output logic [7:0] host_rdata
);
    logic      hund_tick;
    logic      pre_restart;
    rtc_time_t live;

    assign pre_restart = host_we && (host_addr == ADDR_HUND);

    rtc_prescaler #(.OSC_HZ(OSC_HZ), .TICK_HZ(TICK_HZ)) u_prescaler (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .restart  (pre_restart),
        .tick_o   (hund_tick)
    );

    rtc_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (hund_tick),
        .wr_en   (host_we),
        .wr_addr (host_addr),
        .wr_data (host_wdata),
        .live_o  (live)
    );

    rtc_readport u_readport (
        .clk    (clk),
        .rst    (rst),
        .hold   (host_hold),
        .live_i (live),
        .addr   (host_addr),
        .rdata  (host_rdata)
    );

endmodule

// File: tb/test_bcd_rtc_core.sv
module test_bcd_rtc_core;

    logic       clk = 1'b0;
    logic       rst;
    logic       osc_a, osc_b, we, hold;
    logic [3:0] addr;
    logic [7:0] wdata, rd_a, rd_b;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    bcd_rtc_core #(.OSC_HZ(32768), .TICK_HZ(100)) i_bcd_rtc_core (
        .clk(clk), .rst(rst), .osc_tick(osc_a), .host_we(we), .host_addr(addr),
        .host_wdata(wdata), .host_hold(hold), .host_rdata(rd_a)
    );

    // Every timebase pulse is one hundredth here, to reach rollovers quickly.
    bcd_rtc_core #(.OSC_HZ(100), .TICK_HZ(100)) i_bcd_rtc_core_fast (
        .clk(clk), .rst(rst), .osc_tick(osc_b), .host_we(we), .host_addr(addr),
        .host_wdata(wdata), .host_hold(hold), .host_rdata(rd_b)
    );

    int m_hs, m_s, m_m, m_h, m_dow, m_d, m_mo, m_y, m_c;

    function automatic int days_in(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic model_step();
        m_hs++;
        if (m_hs == 100) begin
            m_hs = 0; m_s++;
            if (m_s == 60) begin
                m_s = 0; m_m++;
                if (m_m == 60) begin
                    m_m = 0; m_h++;
                    if (m_h == 24) begin
                        m_h = 0;
                        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                        m_d++;
                        if (m_d > days_in(m_mo, m_y)) begin
                            m_d = 1; m_mo++;
                            if (m_mo == 13) begin
                                m_mo = 1; m_y++;
                                if (m_y == 100) begin
                                    m_y = 0; m_c = 1 - m_c;
                                end
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic set_model(int hs, int s, int m, int h, int dow, int d, int mo, int y, int c);
        m_hs = hs; m_s = s; m_m = m; m_h = h; m_dow = dow;
        m_d = d; m_mo = mo; m_y = y; m_c = c;
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic load_model();
        wr(4'd0, to_bcd(m_hs));
        wr(4'd1, to_bcd(m_s));
        wr(4'd2, to_bcd(m_m));
        wr(4'd3, to_bcd(m_h));
        wr(4'd4, to_bcd(m_dow));
        wr(4'd5, to_bcd(m_d));
        wr(4'd6, to_bcd(m_mo));
        wr(4'd7, to_bcd(m_y));
        wr(4'd8, 8'(m_c));
        repeat (2) @(negedge clk);
    endtask

    // n consecutive pulses on the fast instance, then wait for the visible copy
    task automatic pulse_b(int n);
        @(negedge clk);
        osc_b = 1'b1;
        repeat (n) @(negedge clk);
        osc_b = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_a(int n);
        @(negedge clk);
        osc_a = 1'b1;
        repeat (n) @(negedge clk);
        osc_a = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_b(logic [3:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rd_b;
    endtask

    task automatic check_all(string ctx);
        logic [7:0] v;
        read_b(4'd0, v); check({"R2 hundredths ", ctx}, v, to_bcd(m_hs));
        read_b(4'd1, v); check({"R3 seconds ", ctx}, v, to_bcd(m_s));
        read_b(4'd2, v); check({"R3 minutes ", ctx}, v, to_bcd(m_m));
        read_b(4'd3, v); check({"R4 hours ", ctx}, v, to_bcd(m_h));
        read_b(4'd4, v); check({"R5 weekday ", ctx}, v, to_bcd(m_dow));
        read_b(4'd5, v); check({"R6 date ", ctx}, v, to_bcd(m_d));
        read_b(4'd6, v); check({"R6 month ", ctx}, v, to_bcd(m_mo));
        read_b(4'd7, v); check({"R7 year ", ctx}, v, to_bcd(m_y));
        read_b(4'd8, v); check({"R8 century ", ctx}, v, 8'(m_c));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; osc_a = 1'b0; osc_b = 1'b0; we = 1'b0; hold = 1'b0;
        addr = 4'd0; wdata = 8'h00;
        void'($urandom(32'd17));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R2: reset state
        set_model(0, 0, 0, 0, 1, 1, 1, 0, 0);
        check_all("after reset");

        // R1: fractional prescaler on the 32768 Hz instance
        wr(4'd0, 8'h00);
        pulse_a(327);
        addr = 4'd0; #1; check("R1 327 pulses", rd_a, 8'h00);
        pulse_a(1);
        addr = 4'd0; #1; check("R1 328th pulse", rd_a, 8'h01);
        pulse_a(32768 - 328);
        addr = 4'd0; #1; check("R1 one second hundredths", rd_a, 8'h00);
        addr = 4'd1; #1; check("R1 one second seconds", rd_a, 8'h01);

        // R4 R5 R6 R8: full cascade at the end of year 99
        set_model(99, 59, 59, 23, 7, 31, 12, 99, 0);
        load_model(); pulse_b(1); model_step();
        check_all("R8 century rollover");

        // R7: leap February in year 24
        set_model(99, 59, 59, 23, 3, 28, 2, 24, 1);
        load_model(); pulse_b(1); model_step();
        check_all("R7 leap 24");

        // R7: common February in year 23
        set_model(99, 59, 59, 23, 3, 28, 2, 23, 0);
        load_model(); pulse_b(1); model_step();
        check_all("R7 common 23");

        // R7: year 00 is a leap year
        set_model(99, 59, 59, 23, 6, 28, 2, 0, 0);
        load_model(); pulse_b(1); model_step();
        check_all("R7 leap 00");

        // R6: 30-day month
        set_model(99, 59, 59, 23, 2, 30, 4, 41, 0);
        load_model(); pulse_b(1); model_step();
        check_all("R6 april end");

        // R9: a step landing in a write cycle is dropped
        set_model(40, 30, 20, 10, 3, 15, 6, 50, 0);
        load_model();
        @(negedge clk); osc_b = 1'b1;
        @(negedge clk); osc_b = 1'b0; we = 1'b1; addr = 4'd2; wdata = 8'h45;
        @(negedge clk); we = 1'b0;
        repeat (3) @(negedge clk);
        m_m = 45;
        check_all("R9 write drops step");

        // R9: out-of-range address is ignored and reads zero
        wr(4'd12, 8'h55);
        repeat (2) @(negedge clk);
        read_b(4'd12, v); check("R9 unused address read", v, 8'h00);
        check_all("R9 after unused write");

        // R10: hold freezes the visible copy, release catches up
        @(negedge clk); hold = 1'b1;
        pulse_b(5);
        read_b(4'd0, v); check("R10 held hundredths", v, to_bcd(m_hs));
        read_b(4'd1, v); check("R10 held seconds", v, to_bcd(m_s));
        hold = 1'b0;
        repeat (2) @(negedge clk);
        repeat (5) model_step();
        check_all("R10 after release");

        // Random loads and runs, biased toward rollovers
        for (int it = 0; it < 24; it++) begin
            int mo, y, n;
            mo = 1 + int'($urandom % 12);
            y  = int'($urandom % 100);
            set_model(int'($urandom % 100), int'($urandom % 60), int'($urandom % 60),
                      int'($urandom % 24), 1 + int'($urandom % 7),
                      1 + int'($urandom % days_in(mo, y)), mo, y, int'($urandom % 2));
            if ($urandom % 2 == 1) begin
                m_s = 59; m_m = 59; m_h = 23; m_d = days_in(m_mo, m_y);
                if ($urandom % 2 == 1) m_mo = 12;
                m_d = days_in(m_mo, m_y);
            end
            n = 1 + int'($urandom % 250);
            load_model();
            pulse_b(n);
            repeat (n) model_step();
            check_all("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule